// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic 24-bit down-counter used as a regular time base for an operating system or scheduler. Software programs a start value, selects whether each core clock cycle or each rising edge of a slower external reference counts, and enables the counter. The counter then repeats a fixed period forever. Each time it reaches zero it records the event in a sticky status flag and, when allowed, emits a one-cycle interrupt-pending pulse toward an interrupt controller.

Three word registers sit behind a simple synchronous port: a configuration/status word, a start-value word and a live count word. Reading the configuration word clears the sticky flag unless the read comes from a debugger of the kind that must not disturb state. Writing the live count word restarts the period from zero without raising a tick. A debug-halt input freezes the count while the core is stopped.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads 0 and `tickPend` is low.
- R2: Register index 0 is the configuration word: bit 0 enables counting, bit 1 allows the interrupt pulse, bit 2 selects the source (1 = every core clock, 0 = external reference), bit 16 is the sticky flag and ignores writes; all other bits read 0. Index 1 is the start value, index 2 the live count, index 3 reads 0.
- R3: The start value holds 24 bits; bits 31:24 of the start value and of the live count read as 0.
- R4: While enabled, each count step loads the start value if the count is 0 and otherwise decrements it; while disabled the count does not change.
- R5: A step that moves the count from 1 to 0 sets the flag at that clock edge, and when the interrupt bit is 1, `tickPend` is high for exactly the following cycle.
- R6: A read of index 0 returns the flag and clears it, except when `dbgAcc` and `dbgMaster` are both 1, which leaves it unchanged; a zero event in the same cycle as a clearing read leaves the flag set.
- R7: A write of any data to index 2 sets the count to 0 and clears the flag without raising `tickPend`.
- R8: While `haltIn` is 1 the count does not change.
- R9: With the external source selected, each rising edge of `refClk` produces one step, three core cycles after it is first sampled (two synchronizer stages plus edge detection).
- R10: With a start value of 0, a count of 0 stays 0 and no further flag or pulse occurs.
- R11: Read data appears on `rdData` in the cycle after `rdEn` and returns the value at the moment of the access; in a cycle after no read `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register index |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 32 | Write data |
| dbgAcc | input | 1 | Current read comes from the debugger |
| dbgMaster | input | 1 | Debugger master type; 1 keeps the flag on read |
| haltIn | input | 1 | Core halted; freezes counting |
| refClk | input | 1 | External reference, asynchronous to clk |
| rdData | output | 32 | Registered read data |
| tickPend | output | 1 | One-cycle interrupt-pending pulse |

## Verification
A wrong count or start value shows at the ports only through a read of index 1 or 2 or through the timing of `tickPend`, so the bench compares `rdData` and `tickPend` against a behavioural model on every clock; a count that is off by one moves the next pulse by one cycle and is seen within one period. A flag that is set or cleared wrongly shows on the next read of index 0, which the bench performs after each debugger read, each live-count write and each zero event. A synchronizer with the wrong depth shifts every external-source step by a cycle and appears in the next live-count read.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int IDX_CFG    = 0;
  localparam int IDX_START  = 1;
  localparam int IDX_COUNT  = 2;

  localparam int BIT_RUN    = 0;
  localparam int BIT_IRQ    = 1;
  localparam int BIT_SRC    = 2;

  typedef struct packed {
    logic step;       // one count step this cycle
    logic clrCount;   // live count written: force zero
    logic wrStart;    // start value written
  } ctrlStrobe_t;

endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refIn,
  output logic riseOut
);

  logic [STAGES-1:0] chain;
  logic              lastQ;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= refIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lastQ <= 1'b0;
    else        lastQ <= chain[STAGES-1];
  end

  assign riseOut = chain[STAGES-1] & ~lastQ;

endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic [CNT_W-1:0] startIn,
  output logic [CNT_W-1:0] countOut,
  output logic [CNT_W-1:0] startOut,
  output logic             zeroHit
);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] startQ;
  logic [CNT_W-1:0] countNext;
  logic             atZero;
  logic             atOne;

  assign atZero = (countQ == '0);
  assign atOne  = (countQ == CNT_W'(1));

  always_comb begin
    countNext = countQ;
    if (strobe.clrCount) begin
      countNext = '0;
    end else if (strobe.step) begin
      if (atZero) countNext = startQ;
      else        countNext = countQ - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countQ <= '0;
      startQ <= '0;
    end else begin
      countQ <= countNext;
      if (strobe.wrStart) startQ <= startIn;
    end
  end

  assign zeroHit  = strobe.step & ~strobe.clrCount & atOne;
  assign countOut = countQ;
  assign startOut = startQ;

endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int FLAG_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        cfgIn,
  input  logic              dbgAcc,
  input  logic              dbgMaster,
  input  logic              haltIn,
  input  logic              refRise,
  input  logic [CNT_W-1:0]  countIn,
  input  logic [CNT_W-1:0]  startIn,
  input  logic              zeroHit,
  output ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              tickPend,
  output logic              cfgRun,
  output logic              cfgIrq,
  output logic              flagOut
);

  logic              runQ, irqQ, srcQ, flagQ, pendQ;
  logic [DATA_W-1:0] rdQ;
  logic [DATA_W-1:0] cfgWord;
  logic [DATA_W-1:0] rdMux;
  logic              hitCfg, hitStart, hitCount;
  logic              wrCfg, wrCount, rdCfg, keepFlag, countTick;

  assign hitCfg   = (regAddr == ADDR_W'(IDX_CFG));
  assign hitStart = (regAddr == ADDR_W'(IDX_START));
  assign hitCount = (regAddr == ADDR_W'(IDX_COUNT));

  assign wrCfg    = wrEn & hitCfg;
  assign wrCount  = wrEn & hitCount;
  assign rdCfg    = rdEn & hitCfg;
  assign keepFlag = dbgAcc & dbgMaster;

  assign countTick = srcQ | refRise;

  always_comb begin
    strobe          = '0;
    strobe.step     = runQ & ~haltIn & countTick;
    strobe.clrCount = wrCount;
    strobe.wrStart  = wrEn & hitStart;
  end

  always_comb begin
    cfgWord           = '0;
    cfgWord[BIT_RUN]  = runQ;
    cfgWord[BIT_IRQ]  = irqQ;
    cfgWord[BIT_SRC]  = srcQ;
    cfgWord[FLAG_BIT] = flagQ;
  end

  always_comb begin
    rdMux = '0;
    if (hitCfg)        rdMux = cfgWord;
    else if (hitStart) rdMux = DATA_W'(startIn);
    else if (hitCount) rdMux = DATA_W'(countIn);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runQ  <= 1'b0;
      irqQ  <= 1'b0;
      srcQ  <= 1'b0;
      flagQ <= 1'b0;
      pendQ <= 1'b0;
      rdQ   <= '0;
    end else begin
      if (wrCfg) begin
        runQ <= cfgIn[BIT_RUN];
        irqQ <= cfgIn[BIT_IRQ];
        srcQ <= cfgIn[BIT_SRC];
      end
      if (zeroHit)                  flagQ <= 1'b1;
      else if (wrCount)             flagQ <= 1'b0;
      else if (rdCfg && !keepFlag)  flagQ <= 1'b0;
      pendQ <= zeroHit & irqQ;
      rdQ   <= rdEn ? rdMux : '0;
    end
  end

  assign rdData   = rdQ;
  assign tickPend = pendQ;
  assign cfgRun   = runQ;
  assign cfgIrq   = irqQ;
  assign flagOut  = flagQ;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int FLAG_BIT    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dbgAcc,
  input  logic              dbgMaster,
  input  logic              haltIn,
  input  logic              refClk,
  output logic [DATA_W-1:0] rdData,
  output logic              tickPend
);

  ctrlStrobe_t      strobe;
  logic             refRise;
  logic             zeroHit;
  logic [CNT_W-1:0] countW;
  logic [CNT_W-1:0] startW;
  logic             cfgRun, cfgIrq, flagW;
  logic             unusedWrHi;

  assign unusedWrHi = ^wrData[DATA_W-1:CNT_W];

  tick_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .refIn   (refClk),
    .riseOut (refRise)
  );

  tick_timer_ctrl #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_BIT(FLAG_BIT)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .regAddr   (regAddr),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .cfgIn     (wrData[2:0]),
    .dbgAcc    (dbgAcc),
    .dbgMaster (dbgMaster),
    .haltIn    (haltIn),
    .refRise   (refRise),
    .countIn   (countW),
    .startIn   (startW),
    .zeroHit   (zeroHit),
    .strobe    (strobe),
    .rdData    (rdData),
    .tickPend  (tickPend),
    .cfgRun    (cfgRun),
    .cfgIrq    (cfgIrq),
    .flagOut   (flagW)
  );

  tick_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .startIn  (wrData[CNT_W-1:0]),
    .countOut (countW),
    .startOut (startW),
    .zeroHit  (zeroHit)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wrEn,
  input logic              rdEn,
  input logic              dbgAcc,
  input logic              dbgMaster,
  input logic              haltIn,
  input logic              tickPend,
  input logic [CNT_W-1:0]  countW,
  input logic [CNT_W-1:0]  startW,
  input logic              cfgRun,
  input logic              cfgIrq,
  input logic              flagW
);

  logic wrCount;
  assign wrCount = wrEn && (regAddr == ADDR_W'(2));

  // R5: a pulse always comes with the flag set
  a_r5_pulse_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tickPend |-> flagW);

  // R5: a pulse needs the interrupt bit in the cycle that produced it
  a_r5_pulse_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
    tickPend |-> $past(cfgIrq));

  // R7: writing the live count zeroes it, clears the flag, no pulse
  a_r7_count_write: assert property (@(posedge clk) disable iff (!rst_n)
    wrCount |=> (countW == '0) && !flagW && !tickPend);

  // R8: halted core freezes the count
  a_r8_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    haltIn && !wrCount |=> $stable(countW));

  // R4: disabled counter holds
  a_r4_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgRun && !wrCount |=> $stable(countW));

  // R6: debugger read with master type 1 keeps the flag
  a_r6_dbg_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    flagW && rdEn && (regAddr == ADDR_W'(0)) && dbgAcc && dbgMaster && !wrCount
    |=> flagW);

  // R10: zero start value keeps a zero count at zero
  a_r10_zero_stuck: assert property (@(posedge clk) disable iff (!rst_n)
    (countW == '0) && (startW == '0) && !wrEn |=> (countW == '0) && !tickPend);

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .regAddr   (regAddr),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .dbgAcc    (dbgAcc),
  .dbgMaster (dbgMaster),
  .haltIn    (haltIn),
  .tickPend  (tickPend),
  .countW    (countW),
  .startW    (startW),
  .cfgRun    (cfgRun),
  .cfgIrq    (cfgIrq),
  .flagW     (flagW)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        dbgAcc = 1'b0, dbgMaster = 1'b0, haltIn = 1'b0, refClk = 1'b0;
  logic [31:0] rdData;
  logic        tickPend;

  always #2.5 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .dbgAcc(dbgAcc), .dbgMaster(dbgMaster), .haltIn(haltIn),
    .refClk(refClk), .rdData(rdData), .tickPend(tickPend)
  );

  int    nCmp = 0;
  int    nBad = 0;
  string reqTag = "R1";

  // behavioural reference model
  logic [23:0] mCnt, mStart;
  logic        mRun, mIrq, mSrc, mFlag, mPend;
  logic [31:0] mRd;
  logic        mS1, mS2, mS3;

  always @(posedge clk) begin
    logic stepV, hitV, wrC, rdC;
    logic [31:0] rv;
    if (!rst_n) begin
      mCnt = 0; mStart = 0; mRun = 0; mIrq = 0; mSrc = 0; mFlag = 0;
      mPend = 0; mRd = 0; mS1 = 0; mS2 = 0; mS3 = 0;
    end else begin
      stepV = mRun && !haltIn && (mSrc || (mS2 && !mS3));
      wrC   = wrEn && regAddr == 2;
      rdC   = rdEn && regAddr == 0;
      hitV  = stepV && !wrC && mCnt == 1;
      case (regAddr)
        2'd0:    rv = {15'd0, mFlag, 13'd0, mSrc, mIrq, mRun};
        2'd1:    rv = {8'd0, mStart};
        2'd2:    rv = {8'd0, mCnt};
        default: rv = 0;
      endcase
      mRd   = rdEn ? rv : 32'd0;
      mPend = hitV && mIrq;
      if (hitV) mFlag = 1;
      else if (wrC) mFlag = 0;
      else if (rdC && !(dbgAcc && dbgMaster)) mFlag = 0;
      if (wrC) mCnt = 0;
      else if (stepV) mCnt = (mCnt == 0) ? mStart : mCnt - 1;
      if (wrEn && regAddr == 1) mStart = wrData[23:0];
      if (wrEn && regAddr == 0) {mSrc, mIrq, mRun} = wrData[2:0];
      mS3 = mS2; mS2 = mS1; mS1 = refClk;
    end
  end

  // external reference generator, period of eight core cycles
  logic refRun = 1'b0;
  int   refDiv = 0;
  always @(negedge clk) begin
    if (refRun) begin
      refDiv++;
      if (refDiv == 4) begin refDiv = 0; refClk = ~refClk; end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every clock: rdData (R11) and tickPend (R5) against the model
  task automatic tick();
    @(negedge clk);
    check({reqTag, "/R11 rdData"}, rdData, mRd);
    check({reqTag, "/R5 tickPend"}, {31'd0, tickPend}, {31'd0, mPend});
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    tick();
    wrEn = 1; regAddr = a; wrData = d;
    tick();
    wrEn = 0; wrData = 0;
  endtask

  task automatic rd(logic [1:0] a, logic dbg, logic mst);
    tick();
    rdEn = 1; regAddr = a; dbgAcc = dbg; dbgMaster = mst;
    tick();
    rdEn = 0; dbgAcc = 0; dbgMaster = 0;
  endtask

  task automatic expectRd(logic [1:0] a, logic [31:0] exp, string tag);
    rd(a, 0, 0);
    check(tag, rdData, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    reqTag = "R1";
    check("R1 tickPend after reset", {31'd0, tickPend}, 32'd0);
    expectRd(0, 32'd0, "R1 cfg reset");
    expectRd(1, 32'd0, "R1 start reset");
    expectRd(2, 32'd0, "R1 count reset");

    reqTag = "R3";
    wr(1, 32'hFFFF_FFFF);
    expectRd(1, 32'h00FF_FFFF, "R3 start upper bits");

    reqTag = "R2";
    wr(0, 32'hFFFF_FFF8);
    expectRd(0, 32'd0, "R2 flag and reserved ignore writes");
    expectRd(3, 32'd0, "R2 index 3");

    reqTag = "R4";
    wr(1, 32'd5);
    wr(2, 32'd0);
    wr(0, 32'h7);
    idle(20);
    rd(2, 0, 0);
    idle(7);

    reqTag = "R6";
    wr(0, 32'h6);
    expectRd(2, mCnt, "R4 disabled hold");
    rd(0, 1, 1);
    check("R6 debugger read sees flag", rdData, 32'h0001_0006);
    expectRd(0, 32'h0001_0006, "R6 flag kept after debugger read");
    expectRd(0, 32'h0000_0006, "R6 flag cleared by read");
    rd(0, 1, 0);

    reqTag = "R7";
    wr(0, 32'h7);
    idle(4);
    wr(2, 32'hDEAD_BEEF);
    expectRd(2, 32'd5, "R7 count restarts from zero");
    expectRd(0, 32'h0000_0007, "R7 flag cleared by count write");
    idle(12);

    reqTag = "R8";
    haltIn = 1;
    rd(2, 0, 0);
    idle(9);
    rd(2, 0, 0);
    haltIn = 0;
    idle(10);

    reqTag = "R5";
    wr(0, 32'h5);
    idle(20);
    rd(0, 0, 0);
    wr(0, 32'h7);
    for (int k = 0; k < 4; k++) begin
      idle(k + 2);
      rd(0, 0, 0);
    end

    reqTag = "R9";
    wr(1, 32'd3);
    wr(2, 32'd0);
    wr(0, 32'h3);
    refRun = 1;
    for (int k = 0; k < 12; k++) begin
      idle(5);
      rd(2, 0, 0);
      rd(0, 0, 0);
    end
    haltIn = 1;
    idle(20);
    haltIn = 0;
    idle(20);
    refRun = 0;

    reqTag = "R10";
    wr(0, 32'h7);
    wr(1, 32'd0);
    wr(2, 32'd0);
    idle(20);
    expectRd(2, 32'd0, "R10 count stays zero");
    expectRd(0, 32'h0000_0007, "R10 no flag with zero start");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule